// File: doc/BRIEF.md
# Bridge Fault Supervisor

This block watches the protection flags of a three-phase MOSFET bridge and decides when the bridge must coast. Its inputs are already synchronised digital flags. Some are live conditions: a supply undervoltage pair with hysteresis, an illegal Hall code and over-temperature. Others are events tied to the switching cycle: a high-side gate droop pulse, a bootstrap charge-current flag, a phase-node-high flag and a motor-lead short flag. It also takes the commutation strobe, a disable input and the on-state of the high-side and low-side devices.

The block answers a gate droop by requesting a bootstrap recharge, as long as the number of droops in the current commutation stays within a limit. It times every low-side charge window against a microsecond budget. The lead-short flag is sampled only while a high side is settled on. Faults from droop, bootstrap and lead short are latched, and the next commutation clears them. If no commutation arrives within a stall window while a fault is latched, the block declares a stall, and after that only the disable input or power-up clears it. A status code records which source fired first.

Top module: `bridge_fault_sup`

## Requirements
- R1: `fault_o` is high whenever a latched fault exists or a live condition (undervoltage, bad Hall, over-temperature) is present. `coast_o` is high whenever `fault_o` or `dis_i` is high.
- R2: A droop pulse that arrives while the droop count of the current commutation is below DROOP_LIMIT increments the count and sets `recharge_o` from the next cycle. The request ends in the first cycle after both `boot_ihi_i` and `node_hi_i` are seen low. Coast suppresses and drops the request.
- R3: A droop pulse that arrives when DROOP_LIMIT droops have already been counted in this commutation latches a fault.
- R4: A rising `ls_on_i` starts a window of BOOT_US·CLK_PER_US cycles, counted with the start cycle as 1. If `ls_on_i` is still high in the last cycle of the window while `boot_ihi_i` or `node_hi_i` is high, a fault is latched. If `ls_on_i` falls earlier, the window is abandoned.
- R5: A commutation strobe, when no stall is declared, clears the fault latch, the status code and the droop count.
- R6: While a fault is latched with no commutation, the block declares a stall after STALL_US·CLK_PER_US cycles (`stalled_o`). After that, strobes do not clear the latch.
- R7: `lead_short_i` latches a fault only in a cycle where `hs_on_i` is high and was also high in the previous cycle.
- R8: The undervoltage state is set after power-up reset and whenever `vreg_lo_i` is low. It is cleared when `vreg_hi_i` is high while `vreg_lo_i` is high, and is held otherwise.
- R9: `hall_bad_i` and `temp_hi_i` each raise `fault_o` and `coast_o` in the same cycle without latching.
- R10: `fault_src_o` captures the first source while it is 0. The codes are 1 droop overflow, 2 bootstrap timeout, 3 undervoltage, 4 bad Hall, 5 over-temperature, 6 lead short. The lowest code wins in a tie.
- R11: A high `dis_i` clears the latch, the status code, the droop count, the recharge request, the charge window and the stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous power-up reset, active low |
| dis_i | input | 1 | bridge disable and fault clear, active high |
| comm_stb_i | input | 1 | one-cycle commutation strobe |
| hs_on_i | input | 1 | a high-side device is on |
| ls_on_i | input | 1 | a low-side device is on for charging |
| gs_droop_i | input | 1 | one-cycle high-side gate droop pulse |
| boot_ihi_i | input | 1 | bootstrap charge current still high |
| node_hi_i | input | 1 | phase node still above its low threshold |
| vreg_hi_i | input | 1 | supply above the rising threshold |
| vreg_lo_i | input | 1 | supply above the falling threshold |
| hall_bad_i | input | 1 | illegal Hall code |
| temp_hi_i | input | 1 | over-temperature |
| lead_short_i | input | 1 | motor lead short detected |
| fault_o | output | 1 | active-high fault |
| coast_o | output | 1 | all bridge devices off |
| recharge_o | output | 1 | high side off, low side on to recharge |
| fault_src_o | output | 3 | first fault source code |
| stalled_o | output | 1 | stall declared |

## Verification
The live flags and `dis_i` act on `fault_o` and `coast_o` in the same cycle. Every latched result (fault latch, status code, recharge request, undervoltage state, stall) appears in the cycle after the clock edge that saw its cause. The bootstrap fault follows the edge at which the window count reaches its limit. The bench changes inputs just after each falling edge and compares all outputs against its reference model at the next falling edge, so one rising edge lies between cause and check. Scenarios hold inputs long enough to cross each window limit by a few cycles.

// File: rtl/bfs_pkg.sv
package bfs_pkg;
  typedef enum logic [2:0] {
    SRC_NONE  = 3'd0,
    SRC_DROOP = 3'd1,
    SRC_BOOT  = 3'd2,
    SRC_UV    = 3'd3,
    SRC_HALL  = 3'd4,
    SRC_TEMP  = 3'd5,
    SRC_LEAD  = 3'd6
  } src_e;

  function automatic int unsigned us_to_cycles(int unsigned us, int unsigned per_us);
    return us * per_us;
  endfunction

  // hits[0]=droop .. hits[5]=lead; lowest index wins
  function automatic src_e first_src(logic [5:0] hits);
    src_e r;
    r = SRC_NONE;
    for (int i = 5; i >= 0; i--) begin
      if (hits[i]) r = src_e'(3'(i + 1));
    end
    return r;
  endfunction
endpackage

// File: rtl/bfs_droop_ctr.sv
module bfs_droop_ctr #(
  parameter int unsigned LIMIT = 3,
  localparam int unsigned CW = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_all,
  input  logic          comm,
  input  logic          evt,
  input  logic          coast,
  input  logic          charged,
  output logic          accept,
  output logic          over,
  output logic          rchg,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] cnt_base;

  always_comb begin
    cnt_base = comm ? '0 : cnt;
    accept   = evt && (cnt_base < CW'(LIMIT));
    over     = evt && (cnt_base >= CW'(LIMIT));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      rchg <= 1'b0;
    end else if (clr_all) begin
      cnt  <= '0;
      rchg <= 1'b0;
    end else begin
      cnt <= accept ? cnt_base + 1'b1 : cnt_base;
      if (coast)               rchg <= 1'b0;
      else if (accept)         rchg <= 1'b1;
      else if (rchg && charged) rchg <= 1'b0;
    end
  end
endmodule

// File: rtl/bfs_boot_timer.sv
module bfs_boot_timer #(
  parameter int unsigned WIN = 8500,
  localparam int unsigned TW = $clog2(WIN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_all,
  input  logic ls_on,
  input  logic charge_hi,
  output logic tmo
);
  logic          ls_d, armed;
  logic [TW-1:0] tcnt;

  assign tmo = armed && ls_on && (tcnt == TW'(WIN)) && charge_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ls_d  <= 1'b0;
      armed <= 1'b0;
      tcnt  <= '0;
    end else begin
      ls_d <= ls_on;
      if (clr_all) begin
        armed <= 1'b0;
        tcnt  <= '0;
      end else if (ls_on && !ls_d) begin
        armed <= 1'b1;
        tcnt  <= TW'(1);
      end else if (armed && ls_on) begin
        if (tcnt == TW'(WIN)) armed <= 1'b0;
        else                  tcnt  <= tcnt + 1'b1;
      end else if (!ls_on) begin
        armed <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bfs_stall_watch.sv
module bfs_stall_watch #(
  parameter int unsigned WIN = 50000,
  localparam int unsigned SW = $clog2(WIN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_all,
  input  logic comm,
  input  logic lat,
  output logic stalled
);
  logic [SW-1:0] scnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scnt    <= '0;
      stalled <= 1'b0;
    end else if (clr_all) begin
      scnt    <= '0;
      stalled <= 1'b0;
    end else if (comm) begin
      scnt <= '0;
    end else if (lat && !stalled) begin
      if (scnt == SW'(WIN - 1)) stalled <= 1'b1;
      else                      scnt    <= scnt + 1'b1;
    end else if (!lat) begin
      scnt <= '0;
    end
  end
endmodule

// File: rtl/bridge_fault_sup.sv
module bridge_fault_sup #(
  parameter int unsigned CLK_PER_US  = 50,
  parameter int unsigned BOOT_US     = 170,
  parameter int unsigned STALL_US    = 1000,
  parameter int unsigned DROOP_LIMIT = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dis_i,
  input  logic       comm_stb_i,
  input  logic       hs_on_i,
  input  logic       ls_on_i,
  input  logic       gs_droop_i,
  input  logic       boot_ihi_i,
  input  logic       node_hi_i,
  input  logic       vreg_hi_i,
  input  logic       vreg_lo_i,
  input  logic       hall_bad_i,
  input  logic       temp_hi_i,
  input  logic       lead_short_i,
  output logic       fault_o,
  output logic       coast_o,
  output logic       recharge_o,
  output logic [2:0] fault_src_o,
  output logic       stalled_o
);
  import bfs_pkg::*;

  localparam int unsigned BOOT_CYC  = us_to_cycles(BOOT_US, CLK_PER_US);
  localparam int unsigned STALL_CYC = us_to_cycles(STALL_US, CLK_PER_US);
  localparam int unsigned CW        = $clog2(DROOP_LIMIT + 1);

  logic          uv_q, fault_lat, hs_d;
  src_e          src_q;
  logic          droop_ok, droop_over, boot_tmo, lead_hit, rchg;
  logic          set_any, clr_lat;
  logic [CW-1:0] droop_cnt;
  logic [5:0]    hits;

  assign fault_o     = fault_lat || uv_q || hall_bad_i || temp_hi_i;
  assign coast_o     = fault_o || dis_i;
  assign recharge_o  = rchg && !coast_o;
  assign fault_src_o = src_q;

  assign lead_hit = hs_on_i && hs_d && lead_short_i;
  assign set_any  = !dis_i && (droop_over || boot_tmo || lead_hit);
  assign clr_lat  = comm_stb_i && !stalled_o;
  assign hits     = {lead_hit, temp_hi_i, hall_bad_i, uv_q, boot_tmo, droop_over};

  bfs_droop_ctr #(.LIMIT(DROOP_LIMIT)) u_droop (
    .clk(clk), .rst_n(rst_n), .clr_all(dis_i), .comm(comm_stb_i),
    .evt(gs_droop_i), .coast(coast_o), .charged(!boot_ihi_i && !node_hi_i),
    .accept(droop_ok), .over(droop_over), .rchg(rchg), .cnt(droop_cnt)
  );

  bfs_boot_timer #(.WIN(BOOT_CYC)) u_boot (
    .clk(clk), .rst_n(rst_n), .clr_all(dis_i), .ls_on(ls_on_i),
    .charge_hi(boot_ihi_i || node_hi_i), .tmo(boot_tmo)
  );

  bfs_stall_watch #(.WIN(STALL_CYC)) u_stall (
    .clk(clk), .rst_n(rst_n), .clr_all(dis_i), .comm(comm_stb_i),
    .lat(fault_lat), .stalled(stalled_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uv_q      <= 1'b1;
      hs_d      <= 1'b0;
      fault_lat <= 1'b0;
      src_q     <= SRC_NONE;
    end else begin
      hs_d <= hs_on_i;
      if (!vreg_lo_i)     uv_q <= 1'b1;
      else if (vreg_hi_i) uv_q <= 1'b0;
      if (dis_i) begin
        fault_lat <= 1'b0;
        src_q     <= SRC_NONE;
      end else begin
        fault_lat <= (fault_lat && !clr_lat) || set_any;
        if (clr_lat)                src_q <= SRC_NONE;
        else if (src_q == SRC_NONE) src_q <= first_src(hits);
      end
    end
  end
endmodule

// File: rtl/bfs_checks.sv
module bfs_checks #(
  parameter int unsigned LIMIT = 3,
  localparam int unsigned CW = $clog2(LIMIT + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dis_i,
  input logic          comm_stb_i,
  input logic          hs_on_i,
  input logic          ls_on_i,
  input logic          vreg_hi_i,
  input logic          fault_o,
  input logic          coast_o,
  input logic          recharge_o,
  input logic [2:0]    fault_src_o,
  input logic          stalled_o,
  input logic          uv_q,
  input logic          fault_lat,
  input logic          set_any,
  input logic          droop_ok,
  input logic          droop_over,
  input logic [CW-1:0] droop_cnt,
  input logic          boot_tmo,
  input logic          lead_hit
);
  p_coast_follows_fault_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> coast_o);
  p_droop_recharge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    droop_ok && !dis_i |=> recharge_o || coast_o);
  p_droop_at_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    droop_over |-> droop_cnt == CW'(LIMIT));
  p_boot_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    boot_tmo |-> $past(ls_on_i));
  p_comm_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    comm_stb_i && !stalled_o && !dis_i && !set_any |=> !fault_lat);
  p_stall_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stalled_o && !dis_i |=> stalled_o);
  p_lead_needs_hs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lead_hit |-> $past(hs_on_i));
  p_uv_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    uv_q && !vreg_hi_i |=> uv_q);
  p_src_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fault_src_o != 3'd0 && !comm_stb_i && !dis_i |=> $stable(fault_src_o));
  p_dis_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dis_i |=> !stalled_o && fault_src_o == 3'd0 && !fault_lat);
endmodule

bind bridge_fault_sup bfs_checks #(.LIMIT(DROOP_LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .dis_i(dis_i), .comm_stb_i(comm_stb_i),
  .hs_on_i(hs_on_i), .ls_on_i(ls_on_i), .vreg_hi_i(vreg_hi_i),
  .fault_o(fault_o), .coast_o(coast_o), .recharge_o(recharge_o),
  .fault_src_o(fault_src_o), .stalled_o(stalled_o), .uv_q(uv_q),
  .fault_lat(fault_lat), .set_any(set_any), .droop_ok(droop_ok),
  .droop_over(droop_over), .droop_cnt(droop_cnt), .boot_tmo(boot_tmo),
  .lead_hit(lead_hit)
);

// File: tb/bridge_fault_sup_test.sv
module bridge_fault_sup_test;
  localparam int PER_US = 2, BOOT_US = 10, STALL_US = 20, LIM = 3;
  localparam int BC = BOOT_US * PER_US;
  localparam int SC = STALL_US * PER_US;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dis = 0, comm = 0, hs = 0, ls = 0, gs = 0, bi = 0, nh = 0;
  logic vhi = 0, vlo = 0, hall = 0, temp = 0, lead = 0;
  logic fault, coast, rchg_o, stalled;
  logic [2:0] src;

  int checks = 0, errors = 0;
  string ph = "R8 reset";

  always #10 clk = ~clk;

  bridge_fault_sup #(.CLK_PER_US(PER_US), .BOOT_US(BOOT_US), .STALL_US(STALL_US),
                     .DROOP_LIMIT(LIM)) uut (
    .clk(clk), .rst_n(rst_n), .dis_i(dis), .comm_stb_i(comm), .hs_on_i(hs),
    .ls_on_i(ls), .gs_droop_i(gs), .boot_ihi_i(bi), .node_hi_i(nh),
    .vreg_hi_i(vhi), .vreg_lo_i(vlo), .hall_bad_i(hall), .temp_hi_i(temp),
    .lead_short_i(lead), .fault_o(fault), .coast_o(coast), .recharge_o(rchg_o),
    .fault_src_o(src), .stalled_o(stalled)
  );

  // behavioural reference model
  int m_uv = 1, m_lat = 0, m_src = 0, m_cnt = 0, m_rq = 0, m_arm = 0, m_t = 0;
  int m_lsd = 0, m_hsd = 0, m_stall = 0, m_sc = 0;

  function automatic int exp_fault();
    return (m_lat || m_uv || hall || temp) ? 1 : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_uv = 1; m_lat = 0; m_src = 0; m_cnt = 0; m_rq = 0; m_arm = 0; m_t = 0;
      m_lsd = 0; m_hsd = 0; m_stall = 0; m_sc = 0;
    end else begin
      int f, c, ncnt, nrq, narm, nt, dov, bto, lh, nlat, nsrc, nst, nsc, nuv;
      int clr;
      f = exp_fault();
      dov = 0; bto = 0; lh = 0;
      c = comm ? 0 : m_cnt;
      ncnt = c; nrq = m_rq;
      if (gs && c >= LIM) dov = 1;
      if (f) nrq = 0;
      else if (gs && c < LIM) nrq = 1;
      else if (m_rq && !bi && !nh) nrq = 0;
      if (gs && c < LIM) ncnt = c + 1;
      narm = m_arm; nt = m_t;
      if (ls && !m_lsd) begin narm = 1; nt = 1; end
      else if (m_arm && ls) begin
        if (m_t == BC) begin bto = (bi || nh) ? 1 : 0; narm = 0; end
        else nt = m_t + 1;
      end else if (!ls) narm = 0;
      lh = (hs && m_hsd && lead) ? 1 : 0;
      clr = (comm && !m_stall) ? 1 : 0;
      nlat = ((m_lat && !clr) || dov || bto || lh) ? 1 : 0;
      nsrc = m_src;
      if (clr) nsrc = 0;
      else if (m_src == 0) begin
        if (dov) nsrc = 1; else if (bto) nsrc = 2; else if (m_uv) nsrc = 3;
        else if (hall) nsrc = 4; else if (temp) nsrc = 5; else if (lh) nsrc = 6;
      end
      nst = m_stall; nsc = m_sc;
      if (comm) nsc = 0;
      else if (m_lat && !m_stall) begin
        if (m_sc == SC - 1) nst = 1; else nsc = m_sc + 1;
      end else if (!m_lat) nsc = 0;
      nuv = m_uv;
      if (!vlo) nuv = 1; else if (vhi) nuv = 0;
      if (dis) begin
        nlat = 0; nsrc = 0; ncnt = 0; nrq = 0; narm = 0; nt = 0; nst = 0; nsc = 0;
      end
      m_uv = nuv; m_lat = nlat; m_src = nsrc; m_cnt = ncnt; m_rq = nrq;
      m_arm = narm; m_t = nt; m_stall = nst; m_sc = nsc;
      m_lsd = ls; m_hsd = hs;
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", ph, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      int ef;
      ef = exp_fault();
      chk("fault_o", int'(fault), ef);                               // R1 R9
      chk("coast_o", int'(coast), (ef || dis) ? 1 : 0);              // R1
      chk("recharge_o", int'(rchg_o), (m_rq && !(ef || dis)) ? 1 : 0); // R2
      chk("fault_src_o", int'(src), m_src);                          // R10
      chk("stalled_o", int'(stalled), m_stall);                      // R6
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic pulse_comm();
    comm = 1; step(1); comm = 0;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(2); rst_n = 1; step(3);
    ph = "R8 hysteresis";
    vlo = 1; step(3); vhi = 1; step(2); vhi = 0; step(3);
    vlo = 0; step(2); vlo = 1; step(3); vhi = 1; step(2);
    ph = "R11 disable";
    dis = 1; step(2); dis = 0; step(2);
    ph = "R2 recharge";
    gs = 1; bi = 1; step(1); gs = 0; step(4); bi = 0; step(2);
    ph = "R3 droop limit";
    pulse_comm(); step(1);
    for (int k = 0; k < 4; k++) begin gs = 1; step(1); gs = 0; step(2); end
    step(2);
    ph = "R5 commutation clear";
    pulse_comm(); step(3);
    ph = "R4 boot timeout";
    ls = 1; bi = 1; step(BC + 3); ls = 0; bi = 0; step(2);
    pulse_comm(); step(1);
    ls = 1; step(BC + 3); ls = 0; step(2);
    ls = 1; nh = 1; step(BC / 2); ls = 0; nh = 0; step(3);
    ph = "R7 lead sampling";
    hs = 1; lead = 1; step(1); hs = 0; step(2);
    hs = 1; step(3); hs = 0; lead = 0; step(2);
    ph = "R6 stall";
    step(SC + 4); pulse_comm(); step(3);
    dis = 1; step(1); dis = 0; step(2);
    ph = "R9 live flags";
    hall = 1; step(3); hall = 0; step(2); temp = 1; step(2); temp = 0; step(2);
    pulse_comm(); step(1);
    ph = "R10 priority";
    hall = 1; temp = 1; step(2); hall = 0; temp = 0; step(2);
    pulse_comm(); step(2);
    ph = "R1 disable coast";
    dis = 1; step(2); dis = 0; step(3);
    ph = "R8 reset";
    rst_n = 0; step(1); rst_n = 1; vlo = 0; vhi = 0; step(3);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule